// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers interrupt requests from up to 32 peripherals into one latched status word. Alongside it sits a mask word that software programs, and the block raises a single interrupt line toward the processor. Both words sit on a small register bus made of an address, a write strobe, a width select and a data word. A read is combinational, and a write takes effect at the next rising clock edge.

A request pulse on line i sets status bit i, and the bit then stays set. To acknowledge, software writes the status word, and this rule is not the usual write-one-to-clear. After the write, the status keeps only the bits that are one in the old status, one in the mask and one in the written data. Every other bit in the written half is cleared. Two configuration inputs can force two fixed bits: bit 7 for the serial port and bit 9 for the sound unit. These forced bits are loaded at reset and merged into the status again just before each acknowledge is applied.

Top module: `irq_stat_mask_ctrl`

## Requirements
- R1: While reset (rst_n low, sampled on a rising edge) is applied, the status word becomes bit 7 = force_sio and bit 9 = force_snd with all other bits zero, the mask becomes zero, and irq is low.
- R2: The status word is at byte address 0x070 and the mask word at 0x074. Writes to any other address change neither word, and reads of any other address return zero.
- R3: A 32-bit write (reg_wide = 1) to the mask address stores all 32 data bits in the mask.
- R4: A 16-bit access (reg_wide = 0) touches only bits 15:0. A 16-bit write leaves bits 31:16 of the target word unchanged, and a 16-bit read returns bits 15:0 with bits 31:16 as zero.
- R5: A write to the status address sets each bit in the written half to (old status OR forced bits) AND mask AND written data.
- R6: On an acknowledge write, bit 7 is taken as one when force_sio is high and bit 9 when force_snd is high, even if that status bit was zero before.
- R7: A one on req_pulse[i] at a rising edge sets status bit i after that edge. The bit stays set until an acknowledge clears it. Status bits are never set in any other way.
- R8: When a request and an acknowledge write hit the same bit in the same cycle, the bit ends up set.
- R9: irq is high exactly when (status AND mask) is non-zero. It follows the registered words after each edge, so it can only fall after a write.
- R10: A 32-bit read of either mapped address returns the current contents of that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 12 | Byte address within the register window |
| reg_wr | input | 1 | Write strobe for the current cycle |
| reg_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access to bits 15:0 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, zero-extended on 16-bit reads |
| req_pulse | input | 32 | One pulse line per status bit |
| force_sio | input | 1 | Forces status bit 7 at reset and at each acknowledge |
| force_snd | input | 1 | Forces status bit 9 at reset and at each acknowledge |
| irq | output | 1 | Interrupt output to the processor |

## Verification
The hardest case to reach is a collision inside one cycle: a request and an acknowledge write landing on the same bit, or a 16-bit acknowledge arriving while high-half status bits are pending. The stimulus table builds up pending bits in both halves and then issues the colliding writes on the exact cycle the requests are applied. The forced-bit rule is reached by first clearing bit 7 with a masked-off acknowledge and then acknowledging again with that bit unmasked. A clear bit is then seen to come back set only because of the force input.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
// irqc_pkg: shared types for the interrupt status/mask controller.
// Assumes a single register window decoded on byte addresses.
package irqc_pkg;

    // Which word the current bus address selects.
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_MASK   = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/irqc_addr_decode.sv
`timescale 1ns/1ps
// irqc_addr_decode: turns the bus address, strobe and width into a word select,
// per-word write enables and a bit-lane enable (all bits for 32-bit access,
// low half for 16-bit access).
// Assumes full-address compare; aliases are not decoded.
module irqc_addr_decode
    import irqc_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter logic [ADDR_W-1:0] STATUS_OFS = 12'h070,
    parameter logic [ADDR_W-1:0] MASK_OFS   = 12'h074
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              wide,
    output reg_sel_e          sel,
    output logic              wr_status,
    output logic              wr_mask,
    output logic [DATA_W-1:0] lane_en
);
    localparam int HALF_W = DATA_W / 2;

    // Word select from the address.
    always_comb begin
        if (addr == STATUS_OFS)     sel = SEL_STATUS;
        else if (addr == MASK_OFS)  sel = SEL_MASK;
        else                        sel = SEL_NONE;
    end

    // Write enables only when strobed.
    assign wr_status = wr && (sel == SEL_STATUS);
    assign wr_mask   = wr && (sel == SEL_MASK);

    // Bit lanes covered by this access width.
    assign lane_en = wide ? {DATA_W{1'b1}}
                          : {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

endmodule

// File: rtl/irqc_mask_reg.sv
`timescale 1ns/1ps
// irqc_mask_reg: holds the interrupt mask word; a write stores the data on
// the enabled lanes and leaves the rest.
// Assumes lane_en already reflects the access width.
module irqc_mask_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mask,
    input  logic [DATA_W-1:0] lane_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask
);

    // Mask storage with lane-merged writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (wr_mask) mask <= (mask & ~lane_en) | (wdata & lane_en);
    end

    p_mask_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (((mask ^ $past(wdata)) & $past(lane_en)) == '0));

    p_mask_upper_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (((mask ^ $past(mask)) & ~$past(lane_en)) == '0));

    p_mask_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask |=> $stable(mask));

endmodule

// File: rtl/irqc_status_reg.sv
`timescale 1ns/1ps
// irqc_status_reg: latched interrupt status. Per bit: a request sets it (and
// wins over an acknowledge), an acknowledge on an enabled lane reloads it
// with (bit | forced) & mask & data, otherwise it holds.
// Assumes force_vec is stable configuration.
module irqc_status_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_status,
    input  logic [DATA_W-1:0] lane_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] force_vec,
    input  logic [DATA_W-1:0] req_pulse,
    output logic [DATA_W-1:0] status
);
    logic [DATA_W-1:0] status_nxt;

    // Next-state logic, one cell per bit.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic kept;
        assign kept = (status[b] | force_vec[b]) & mask[b] & wdata[b];
        assign status_nxt[b] = req_pulse[b]                 ? 1'b1 :
                               (wr_status && lane_en[b])    ? kept :
                                                              status[b];
    end

    // Status storage; reset loads the forced bits.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= force_vec;
        else        status <= status_nxt;
    end

    p_req_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pulse != '0) |=> ((status & $past(req_pulse)) == $past(req_pulse)));

    p_no_spurious_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_status |=> ((status & ~$past(status | req_pulse)) == '0));

    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_status |=> ((status & $past(lane_en)
                        & ~$past(((status | force_vec) & mask & wdata) | req_pulse)) == '0));

    p_ack_upper_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_status |=> (((status ^ $past(status)) & ~$past(lane_en) & ~$past(req_pulse)) == '0));

endmodule

// File: rtl/irq_stat_mask_ctrl.sv
`timescale 1ns/1ps
// irq_stat_mask_ctrl: top of the interrupt status/mask controller. Decodes
// the register bus, holds mask and status words, returns readback and drives
// irq = |(status & mask).
// Assumes synchronous active-low reset and single-cycle register accesses.
module irq_stat_mask_ctrl
    import irqc_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int SIO_BIT = 7,
    parameter int SND_BIT = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_wide,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] req_pulse,
    input  logic              force_sio,
    input  logic              force_snd,
    output logic              irq
);
    reg_sel_e          sel;
    logic              wr_status;
    logic              wr_mask;
    logic [DATA_W-1:0] lane_en;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] status;
    logic [DATA_W-1:0] force_vec;
    logic [DATA_W-1:0] rd_word;

    // Forced-bit vector built from the two configuration inputs.
    for (genvar b = 0; b < DATA_W; b++) begin : g_force
        if (b == SIO_BIT)      begin : g_sio assign force_vec[b] = force_sio; end
        else if (b == SND_BIT) begin : g_snd assign force_vec[b] = force_snd; end
        else                   begin : g_off assign force_vec[b] = 1'b0;      end
    end

    irqc_addr_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) decode_i (
        .addr(reg_addr), .wr(reg_wr), .wide(reg_wide),
        .sel(sel), .wr_status(wr_status), .wr_mask(wr_mask), .lane_en(lane_en)
    );

    irqc_mask_reg #(.DATA_W(DATA_W)) mask_i (
        .clk(clk), .rst_n(rst_n), .wr_mask(wr_mask),
        .lane_en(lane_en), .wdata(reg_wdata), .mask(mask)
    );

    irqc_status_reg #(.DATA_W(DATA_W)) status_i (
        .clk(clk), .rst_n(rst_n), .wr_status(wr_status),
        .lane_en(lane_en), .wdata(reg_wdata), .mask(mask),
        .force_vec(force_vec), .req_pulse(req_pulse), .status(status)
    );

    // Readback mux, limited to the lanes of the access width.
    always_comb begin
        unique case (sel)
            SEL_STATUS: rd_word = status;
            SEL_MASK:   rd_word = mask;
            default:    rd_word = '0;
        endcase
    end
    assign reg_rdata = rd_word & lane_en;

    // Interrupt output from pending unmasked bits.
    assign irq = |(status & mask);

    p_irq_fall_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_wr));

endmodule

// File: tb/irq_stat_mask_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_stat_mask_ctrl_tb_top;
    localparam logic [11:0] A_ST = 12'h070;
    localparam logic [11:0] A_MK = 12'h074;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic        wide;
        logic [31:0] data;
        logic [31:0] req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h000, 1'b1, 32'h0000_0000, 32'h0000_0005},
        '{1'b1, A_MK,    1'b1, 32'h0000_0085, 32'h0000_0000},
        '{1'b0, 12'h000, 1'b1, 32'h0000_0000, 32'h8000_0000},
        '{1'b1, A_ST,    1'b1, 32'hFFFF_FFFF, 32'h0000_0000},
        '{1'b1, A_ST,    1'b1, 32'h0000_0004, 32'h0000_0000},
        '{1'b1, A_MK,    1'b0, 32'hDEAD_8001, 32'h0000_0000},
        '{1'b0, 12'h000, 1'b1, 32'h0000_0000, 32'h0001_8001},
        '{1'b1, A_ST,    1'b0, 32'h0000_0000, 32'h0000_0010},
        '{1'b1, A_MK,    1'b1, 32'hFFFF_FFFF, 32'h0000_0000},
        '{1'b1, A_ST,    1'b1, 32'h7FFF_FFFF, 32'h0000_0200},
        '{1'b1, 12'h078, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000},
        '{1'b1, A_ST,    1'b1, 32'h0000_0000, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_wide = 1'b1;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] req_pulse = '0;
    logic        force_sio = 1'b1;
    logic        force_snd = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [31:0] m_st, m_mk;

    always #4 clk = ~clk;

    irq_stat_mask_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wide(reg_wide), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_pulse(req_pulse), .force_sio(force_sio), .force_snd(force_snd),
        .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] frc();
        return (32'(force_snd) << 9) | (32'(force_sio) << 7);
    endfunction

    // Reference model from the requirements.
    task automatic model(input vec_t v);
        logic [31:0] lane, tmp;
        lane = v.wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        if (v.wr && v.addr == A_ST) begin
            tmp  = (m_st | frc()) & m_mk & v.data;
            m_st = (m_st & ~lane) | (tmp & lane);
        end
        if (v.wr && v.addr == A_MK) m_mk = (m_mk & ~lane) | (v.data & lane);
        m_st = m_st | v.req;
    endtask

    task automatic step(input vec_t v);
        @(negedge clk);
        reg_wr = v.wr; reg_addr = v.addr; reg_wide = v.wide;
        reg_wdata = v.data; req_pulse = v.req;
        @(posedge clk);
        #1;
        reg_wr = 1'b0; req_pulse = '0; reg_wide = 1'b1;
        model(v);
    endtask

    task automatic rd(input logic [11:0] a, input logic w, output logic [31:0] val);
        reg_addr = a; reg_wide = w; #1; val = reg_rdata; reg_wide = 1'b1;
    endtask

    task automatic verify(input string tag);
        logic [31:0] s, m;
        rd(A_ST, 1'b1, s);
        rd(A_MK, 1'b1, m);
        check({tag, " status"}, s, m_st);
        check({tag, " mask"}, m, m_mk);
        check({tag, " irq"}, 32'(irq), 32'(|(m_st & m_mk)));
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        m_st = frc(); m_mk = '0;
        verify("R1 reset");
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        // R1 reset with serial force only.
        do_reset();

        // Table walk: R5 R7 R8 R10 R4 R2 against the model.
        for (int i = 0; i < NV; i++) begin
            step(VECS[i]);
            verify("R10 table");
        end

        // R2: unmapped read returns zero, write leaves words.
        step('{1'b1, A_MK, 1'b1, 32'hAAAA_0000, 32'h0});
        step('{1'b1, 12'h07C, 1'b1, 32'h1234_5678, 32'h0});
        verify("R2 unmapped write");
        rd(12'h078, 1'b1, v);
        check("R2 unmapped read", v, 32'h0);

        // R3 / R4: 16-bit mask write keeps upper half; 16-bit read zero-extends.
        step('{1'b1, A_MK, 1'b0, 32'hFFFF_1234, 32'h0});
        check("R4 mask upper hold", m_mk, 32'hAAAA_1234);
        verify("R4 mask 16-bit");
        rd(A_MK, 1'b0, v);
        check("R4 16-bit read", v, 32'h0000_1234);
        step('{1'b1, A_MK, 1'b1, 32'h5A5A_C3C3, 32'h0});
        verify("R3 mask 32-bit");

        // R9: pending but masked gives no irq; unmasking raises it.
        step('{1'b1, A_MK, 1'b1, 32'h0, 32'h0});
        step('{1'b1, A_ST, 1'b1, 32'h0, 32'h0});
        step('{1'b0, 12'h0, 1'b1, 32'h0, 32'h0000_0004});
        check("R9 masked no irq", 32'(irq), 32'h0);
        step('{1'b1, A_MK, 1'b1, 32'h0000_0084, 32'h0});
        check("R9 unmasked irq", 32'(irq), 32'h1);

        // R6: bit 7 clear, then ack with bit 7 set brings it back via force.
        step('{1'b1, A_ST, 1'b1, 32'h0000_0004, 32'h0});
        check("R6 bit7 cleared", m_st & 32'h80, 32'h0);
        verify("R6 pre");
        step('{1'b1, A_ST, 1'b1, 32'h0000_0084, 32'h0});
        verify("R6 forced bit");
        check("R6 bit7 forced", m_st & 32'h80, 32'h80);

        // R8: request and clearing ack on the same bit, same cycle.
        step('{1'b1, A_ST, 1'b1, 32'h0, 32'h0000_0008});
        verify("R8 set beats clear");

        // R1 again with the other configuration; R6 on bit 9.
        force_sio = 1'b0; force_snd = 1'b1;
        do_reset();
        step('{1'b1, A_MK, 1'b1, 32'h0000_0280, 32'h0});
        step('{1'b1, A_ST, 1'b1, 32'h0000_0280, 32'h0});
        verify("R6 bit9 forced");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule